// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies data without CPU help. When it is started, it reads a 16-byte transfer descriptor from memory through a word-read port. It then moves beats from a source address to a destination address over a simple sized read/write bus. Each beat is one read followed by one write. When a descriptor's block is finished, the engine follows the descriptor's link word and fetches the next descriptor. The chain ends at a link of zero.

Descriptors hold end addresses, not start addresses. For each side that increments, the engine works out the first address itself. Transfers are paced by a trigger input. Depending on the trigger action, one trigger moves one beat, one descriptor's block, or the whole chain. Beat pacing is the usual choice when a peripheral signals that each sample is ready.

The CPU side supplies the address of the first descriptor and a start pulse. It reads back a busy level, a sticky error flag for a descriptor marked invalid, and single-cycle block-done, chain-done and trigger-overrun pulses.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, neither `dr_req` nor `bus_req` is asserted. `err`, `blk_done`, `xfer_done` and `overrun` are low after reset. The two request outputs are never high together.
- R2: A descriptor is fetched as four word reads at base, base+4, base+8 and base+12. The base has its low four bits forced to zero.
  - Word 0 holds the control half-word in bits 15:0 and the beat count in bits 31:16.
  - Control bit 0 is valid. Bits 2:1 give the beat size (0 byte, 1 half-word, 2 word; 3 is treated as word). Bit 3 enables source increment. Bit 4 enables destination increment.
  - Word 1 is the source address, word 2 the destination address and word 3 the next-descriptor link.
- R3: On an incrementing side, the stored address is the end address. The first beat uses end minus count times beat size, and each later beat adds the beat size.
- R4: On a non-incrementing side, every beat of the block uses the stored address unchanged.
- R5: `bus_size` carries the beat-size code, and data is right-justified. The write data of a beat equals the data read in that beat, masked to the beat size. Address and direction hold steady until `bus_ack`.
- R6: With `trig_mode` = 0 (beat), each accepted trigger moves exactly one beat.
- R7: With `trig_mode` = 1 (block), one trigger moves all beats of the current descriptor. The next descriptor needs a new trigger.
- R8: With `trig_mode` = 2 (transaction), nothing moves before the first trigger. That single trigger then runs every descriptor of the chain.
- R9: A non-zero link causes the next descriptor to be fetched and run. A zero link ends the run: `xfer_done` pulses together with the last `blk_done`, and `busy` falls in that same cycle.
- R10: `blk_done` pulses once for each completed descriptor.
- R11: A fetched descriptor whose valid bit is clear stops the engine. `err` rises, `busy` falls, and no data-bus access is made. `err` stays set until the next accepted start.
- R12: A start pulse while idle runs the chain again from `first_desc` without any descriptor being rewritten. A start pulse while busy is ignored.
- R13: A trigger that arrives while a beat is in progress is held as one pending trigger. A further trigger while one is already pending produces an `overrun` pulse and is dropped.
- R14: Triggers that arrive while the channel is idle are discarded and do not count toward a later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted only while idle |
| first_desc | input | 32 | Address of the first descriptor |
| trig_mode | input | 2 | 0 beat, 1 block, 2 transaction |
| trig | input | 1 | Trigger; each high cycle is one trigger |
| dr_req | output | 1 | Descriptor word read request |
| dr_addr | output | 32 | Descriptor word address |
| dr_ack | input | 1 | Descriptor read data valid |
| dr_rdata | input | 32 | Descriptor read data |
| bus_req | output | 1 | Data bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_size | output | 2 | Beat size code |
| bus_addr | output | 32 | Data bus address |
| bus_wdata | output | 32 | Right-justified write data |
| bus_ack | input | 1 | Data bus access complete |
| bus_rdata | input | 32 | Right-justified read data |
| busy | output | 1 | Channel running |
| err | output | 1 | Invalid descriptor seen (sticky) |
| blk_done | output | 1 | Pulse: one descriptor finished |
| xfer_done | output | 1 | Pulse: whole chain finished |
| overrun | output | 1 | Pulse: trigger dropped |

## Verification
Data-bus writes have no fixed latency. Each write is therefore checked in the cycle where `bus_req`, `bus_we` and `bus_ack` are all high, and it is compared in order against a queue of expected address and data pairs. That queue is filled from bench memory before each trigger.

Descriptor fetch takes about ten cycles after a start. The bench therefore waits twenty cycles before triggering and before checking that nothing moved.

A beat finishes within about six cycles of a trigger. Beat-mode write counts are sampled fifteen cycles after each trigger. The overrun case drives three triggers on three consecutive cycles, so the third one lands while the first beat's read is still pending. The done, error and overrun pulses are counted on falling edges, and the counts are compared once the channel has gone idle.

// File: rtl/dmae_pkg.sv
// Shared constants and types for the descriptor-chained DMA engine.
// Assumes 32-bit addresses and data and a fixed four-word descriptor.
package dmae_pkg;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ALIGN_W    = IDX_W + 2;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [1:0] TA_BEAT  = 2'd0;
    localparam logic [1:0] TA_BLOCK = 2'd1;
    localparam logic [1:0] TA_CHAIN = 2'd2;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR} st_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [10:0]      rsvd;
        logic             dst_inc;
        logic             src_inc;
        logic [1:0]       size;
        logic             valid;
    } ctl_word_t;

    typedef struct packed {
        ctl_word_t         w0;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] nxt;
    } desc_t;

    // Lane mask for a right-justified beat of the given size code.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] s);
        case (s)
            SZ_BYTE: lane_mask = 32'h0000_00FF;
            SZ_HALF: lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/dmae_desc_fetch.sv
// Reads one descriptor as DESC_WORDS consecutive word reads.
// Assumes the memory keeps dr_ack low until it answers the current request.
module dmae_desc_fetch
    import dmae_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] base,
    output logic              dr_req,
    output logic [WORD_W-1:0] dr_addr,
    input  logic              dr_ack,
    input  logic [WORD_W-1:0] dr_rdata,
    output logic              done,
    output desc_t             desc
);
    logic                      active;
    logic [IDX_W-1:0]          idx;
    logic [WORD_W-ALIGN_W-1:0] base_q;

    // Sequence the word reads and shift each answer into the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
            done   <= 1'b0;
            desc   <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                idx    <= '0;
                base_q <= base[WORD_W-1:ALIGN_W];
            end else if (active && dr_ack) begin
                desc <= {desc[DESC_WORDS*WORD_W-WORD_W-1:0], dr_rdata};
                idx  <= idx + 1'b1;
                if (idx == IDX_W'(DESC_WORDS-1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign dr_req  = active;
    assign dr_addr = {base_q, idx, 2'b00};
endmodule

// File: rtl/dmae_addr_base.sv
// Turns a stored end address into the first beat address for an incrementing side.
// Purely combinational; a non-incrementing side passes its address through.
module dmae_addr_base
    import dmae_pkg::*;
(
    input  logic [WORD_W-1:0] end_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        sz,
    input  logic              inc,
    output logic [WORD_W-1:0] start_addr
);
    logic [WORD_W-1:0] span;

    // Block size in bytes is count shifted by the size code.
    always_comb begin
        span       = {{(WORD_W-CNT_W){1'b0}}, cnt} << sz;
        start_addr = inc ? (end_addr - span) : end_addr;
    end
endmodule

// File: rtl/dmae_trig.sv
// Holds one pending trigger per channel and flags a dropped one.
// Assumes take is only raised while pend is high.
module dmae_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic trig,
    input  logic take,
    output logic pend,
    output logic overrun
);
    // Track the pending trigger; discard everything while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (!armed) begin
                pend <= 1'b0;
            end else if (trig) begin
                if (pend && !take) overrun <= 1'b1;
                pend <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_chain_engine.sv
// Single DMA channel: fetches chained descriptors and moves paced beats.
// Assumes both memory ports hold their ack low until each request is served.
module dma_chain_engine
    import dmae_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] first_desc,
    input  logic [1:0]        trig_mode,
    input  logic              trig,
    output logic              dr_req,
    output logic [WORD_W-1:0] dr_addr,
    input  logic              dr_ack,
    input  logic [WORD_W-1:0] dr_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              busy,
    output logic              err,
    output logic              blk_done,
    output logic              xfer_done,
    output logic              overrun
);
    st_e               st;
    logic              fetch_go, f_done, pend, take, run_q;
    logic              s_inc, d_inc;
    logic [1:0]        sz, f_sz;
    logic [CNT_W-1:0]  remain;
    logic [WORD_W-1:0] fetch_addr, src_a, dst_a, nxt_a, data_q;
    logic [WORD_W-1:0] src_first, dst_first, step;
    desc_t             f_desc;

    dmae_desc_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(fetch_addr),
        .dr_req(dr_req), .dr_addr(dr_addr), .dr_ack(dr_ack),
        .dr_rdata(dr_rdata), .done(f_done), .desc(f_desc)
    );

    dmae_addr_base u_src (
        .end_addr(f_desc.src), .cnt(f_desc.w0.cnt), .sz(f_sz),
        .inc(f_desc.w0.src_inc), .start_addr(src_first)
    );

    dmae_addr_base u_dst (
        .end_addr(f_desc.dst), .cnt(f_desc.w0.cnt), .sz(f_sz),
        .inc(f_desc.w0.dst_inc), .start_addr(dst_first)
    );

    dmae_trig u_trig (
        .clk(clk), .rst_n(rst_n), .armed(busy), .trig(trig),
        .take(take), .pend(pend), .overrun(overrun)
    );

    // Decode size code 3 as word and derive per-beat stride and trigger use.
    always_comb begin
        f_sz = (f_desc.w0.size == 2'b11) ? SZ_WORD : f_desc.w0.size;
        step = WORD_W'(1) << sz;
        take = (st == S_WAIT) && pend;
        busy = (st != S_IDLE);
    end

    // Drive the data bus from the beat phase.
    always_comb begin
        bus_req   = (st == S_RD) || (st == S_WR);
        bus_we    = (st == S_WR);
        bus_size  = sz;
        bus_addr  = (st == S_WR) ? dst_a : src_a;
        bus_wdata = data_q;
    end

    // Channel sequencer: fetch, wait for trigger, read, write, chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; fetch_go <= 1'b0; fetch_addr <= '0;
            src_a <= '0; dst_a <= '0; nxt_a <= '0; data_q <= '0;
            remain <= '0; sz <= SZ_BYTE; s_inc <= 1'b0; d_inc <= 1'b0;
            run_q <= 1'b0; err <= 1'b0; blk_done <= 1'b0; xfer_done <= 1'b0;
        end else begin
            fetch_go  <= 1'b0;
            blk_done  <= 1'b0;
            xfer_done <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    st <= S_FETCH; fetch_go <= 1'b1; fetch_addr <= first_desc;
                    err <= 1'b0; run_q <= 1'b0;
                end
                S_FETCH: if (f_done) begin
                    if (!f_desc.w0.valid) begin
                        err <= 1'b1; st <= S_IDLE;
                    end else begin
                        src_a <= src_first; dst_a <= dst_first;
                        nxt_a <= f_desc.nxt; remain <= f_desc.w0.cnt;
                        sz <= f_sz; s_inc <= f_desc.w0.src_inc;
                        d_inc <= f_desc.w0.dst_inc;
                        st <= (trig_mode == TA_CHAIN && run_q) ? S_RD : S_WAIT;
                    end
                end
                S_WAIT: if (pend) begin
                    run_q <= 1'b1; st <= S_RD;
                end
                S_RD: if (bus_ack) begin
                    data_q <= bus_rdata & lane_mask(sz); st <= S_WR;
                end
                S_WR: if (bus_ack) begin
                    if (s_inc) src_a <= src_a + step;
                    if (d_inc) dst_a <= dst_a + step;
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1)) begin
                        blk_done <= 1'b1;
                        if (nxt_a == '0) begin
                            xfer_done <= 1'b1; st <= S_IDLE;
                        end else begin
                            fetch_go <= 1'b1; fetch_addr <= nxt_a; st <= S_FETCH;
                        end
                    end else begin
                        st <= (trig_mode == TA_BEAT) ? S_WAIT : S_RD;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmae_chk.sv
// Protocol checker for dma_chain_engine, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module dmae_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dr_req,
    input logic [31:0] dr_addr,
    input logic        bus_req,
    input logic        bus_we,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_addr,
    input logic        bus_ack,
    input logic        busy,
    input logic        err,
    input logic        blk_done,
    input logic        xfer_done,
    input logic        overrun
);
    // R1: idle channel makes no requests
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !dr_req));
    // R1: ports never requested together
    assert_one_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dr_req, bus_req}));
    // R2: descriptor reads are word aligned
    assert_desc_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req |-> (dr_addr[1:0] == 2'b00));
    // R5: request held steady until acknowledged
    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R5: only legal size codes reach the bus
    assert_size_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_size != 2'b11));
    // R9: chain end drops busy
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !busy);
    // R10: chain end coincides with final block end
    assert_last_blk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> blk_done);
    // R11: error leaves the channel stopped
    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R13: overrun only reported for a running channel
    assert_ovr_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(busy));
endmodule

bind dma_chain_engine dmae_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dr_req(dr_req), .dr_addr(dr_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .busy(busy), .err(err),
    .blk_done(blk_done), .xfer_done(xfer_done), .overrun(overrun)
);

// File: tb/sim_dma_chain_engine.sv
module sim_dma_chain_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] first_desc = '0;
    logic [1:0]  trig_mode = 2'd0;
    logic        trig = 1'b0;
    logic        dr_req, bus_req, bus_we;
    logic [31:0] dr_addr, bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        dr_ack = 1'b0, bus_ack = 1'b0;
    logic [31:0] dr_rdata = '0, bus_rdata = '0;
    logic        busy, err, blk_done, xfer_done, overrun;

    logic [7:0] mem [0:1023];

    int checks = 0, fails = 0;
    int nwr = 0, blk_cnt = 0, xfer_cnt = 0, ovr_cnt = 0;

    typedef struct { logic [31:0] a; logic [31:0] d; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    dma_chain_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .first_desc(first_desc),
        .trig_mode(trig_mode), .trig(trig), .dr_req(dr_req), .dr_addr(dr_addr),
        .dr_ack(dr_ack), .dr_rdata(dr_rdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .err(err),
        .blk_done(blk_done), .xfer_done(xfer_done), .overrun(overrun)
    );

    function automatic logic [31:0] rdm(input logic [31:0] a, input logic [1:0] s);
        int i;
        i = int'(a[9:0]);
        case (s)
            2'd0:    rdm = {24'h0, mem[i]};
            2'd1:    rdm = {16'h0, mem[(i+1)%1024], mem[i]};
            default: rdm = {mem[(i+3)%1024], mem[(i+2)%1024], mem[(i+1)%1024], mem[i]};
        endcase
    endfunction

    // Memory model: one-cycle answer on both ports.
    always @(posedge clk) begin
        dr_ack  <= 1'b0;
        bus_ack <= 1'b0;
        if (dr_req && !dr_ack) begin
            dr_ack   <= 1'b1;
            dr_rdata <= rdm(dr_addr, 2'd2);
        end
        if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                mem[bus_addr[9:0]] <= bus_wdata[7:0];
                if (bus_size >= 2'd1) mem[bus_addr[9:0]+10'd1] <= bus_wdata[15:8];
                if (bus_size >= 2'd2) begin
                    mem[bus_addr[9:0]+10'd2] <= bus_wdata[23:16];
                    mem[bus_addr[9:0]+10'd3] <= bus_wdata[31:24];
                end
            end else begin
                bus_rdata <= rdm(bus_addr, bus_size);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Monitor: scoreboard pop on each completed write; count pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (blk_done) blk_cnt++;
            if (xfer_done) xfer_cnt++;
            if (overrun) ovr_cnt++;
            if (bus_req && bus_we && bus_ack) begin
                nwr++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write addr", bus_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(bus_addr == e.a, "R3", "write address", bus_addr, e.a);
                    chk(bus_wdata == e.d, "R5", "write data", bus_wdata, e.d);
                end
            end
        end
    end

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a+k)%1024] = v[8*k +: 8];
    endtask

    task automatic put_desc(input int base, input int cnt, input int sz,
                            input bit si, input bit di, input bit vld,
                            input int src, input int dst, input int nxt);
        put32(base, {cnt[15:0], 11'h0, di, si, sz[1:0], vld});
        put32(base + 4, src);
        put32(base + 8, dst);
        put32(base + 12, nxt);
    endtask

    // Driver: push the expected writes of one block from current memory.
    task automatic push_block(input int s0, input bit si, input int d0, input bit di,
                              input int cnt, input int sz);
        int w;
        w = 1 << sz;
        for (int i = 0; i < cnt; i++) begin
            exp_t e;
            e.a = di ? d0 + i*w : d0;
            e.d = rdm(si ? s0 + i*w : s0, sz[1:0]);
            exp_q.push_back(e);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(input int d, input logic [1:0] m);
        @(negedge clk);
        first_desc = d; trig_mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        trig = 1'b1;
        cyc(n);
        trig = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int b_w, b_b, b_x, b_o;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        cyc(5);
        chk(busy == 0 && !dr_req && !bus_req, "R1", "reset idle",
            {29'h0, busy, dr_req, bus_req}, 32'h0);
        chk({err, blk_done, xfer_done, overrun} == 4'h0, "R1", "reset flags",
            {28'h0, err, blk_done, xfer_done, overrun}, 32'h0);
        rst_n = 1'b1;
        cyc(2);

        // R8 R3 R5: one word descriptor, transaction mode.
        put_desc(32'h100, 4, 2, 1, 1, 1, 32'h210, 32'h310, 0);
        push_block(32'h200, 1, 32'h300, 1, 4, 2);
        b_w = nwr; b_b = blk_cnt; b_x = xfer_cnt;
        go(32'h100, 2'd2);
        cyc(20);
        chk(busy == 1 && nwr == b_w, "R8", "no move before trigger", nwr - b_w, 0);
        pulse(1);
        wait_idle();
        cyc(2);
        chk(nwr - b_w == 4, "R8", "beats in transaction", nwr - b_w, 4);
        chk(blk_cnt - b_b == 1 && xfer_cnt - b_x == 1, "R9", "done pulses",
            (blk_cnt - b_b) * 16 + xfer_cnt - b_x, 32'h11);

        // R6 R4: beat mode, half-words, fixed source.
        put_desc(32'h100, 3, 1, 0, 1, 1, 32'h220, 32'h326, 0);
        b_w = nwr; b_x = xfer_cnt;
        go(32'h100, 2'd0);
        cyc(20);
        for (int i = 0; i < 3; i++) begin
            put32(32'h220, 32'h0000_A100 + i);
            push_block(32'h220, 0, 32'h320 + 2*i, 1, 1, 1);
            pulse(1);
            cyc(15);
            chk(nwr - b_w == i + 1, "R6", "one beat per trigger", nwr - b_w, i + 1);
        end
        wait_idle();
        chk(xfer_cnt - b_x == 1 && !busy, "R9", "beat chain end", xfer_cnt - b_x, 1);

        // R7 R9 R10 R4: block mode, chained byte descriptors, fixed destination.
        put_desc(32'h110, 2, 0, 1, 1, 1, 32'h232, 32'h342, 32'h120);
        put_desc(32'h120, 3, 0, 1, 0, 1, 32'h243, 32'h350, 0);
        push_block(32'h230, 1, 32'h340, 1, 2, 0);
        push_block(32'h240, 1, 32'h350, 0, 3, 0);
        b_w = nwr; b_b = blk_cnt; b_x = xfer_cnt;
        go(32'h110, 2'd1);
        cyc(20);
        pulse(1);
        cyc(40);
        chk(nwr - b_w == 2, "R7", "first block only", nwr - b_w, 2);
        chk(blk_cnt - b_b == 1 && xfer_cnt == b_x && busy, "R10", "one block done",
            blk_cnt - b_b, 1);
        pulse(1);
        wait_idle();
        cyc(2);
        chk(nwr - b_w == 5, "R9", "linked block ran", nwr - b_w, 5);
        chk(blk_cnt - b_b == 2 && xfer_cnt - b_x == 1, "R10", "block count",
            blk_cnt - b_b, 2);
        chk(mem[32'h350] == mem[32'h242], "R4", "fixed dest holds last",
            mem[32'h350], mem[32'h242]);

        // R11: invalid descriptor.
        put_desc(32'h130, 2, 2, 1, 1, 0, 32'h208, 32'h308, 0);
        b_w = nwr;
        go(32'h130, 2'd2);
        cyc(20);
        pulse(1);
        cyc(10);
        chk(err == 1 && busy == 0, "R11", "err stop", {30'h0, err, busy}, 32'h2);
        chk(nwr == b_w, "R11", "no data access", nwr - b_w, 0);

        // R12: restart from first descriptor; start while busy ignored.
        put_desc(32'h100, 4, 2, 1, 1, 1, 32'h210, 32'h310, 0);
        for (int i = 0; i < 16; i++) mem[32'h200 + i] = 8'(8'h5A ^ i);
        push_block(32'h200, 1, 32'h300, 1, 4, 2);
        b_w = nwr; b_x = xfer_cnt;
        go(32'h100, 2'd2);
        cyc(1);
        chk(err == 0, "R11", "err cleared by start", err, 0);
        cyc(18);
        go(32'h130, 2'd2);
        pulse(1);
        wait_idle();
        cyc(2);
        chk(nwr - b_w == 4 && err == 0, "R12", "restart ran", nwr - b_w, 4);
        chk(xfer_cnt - b_x == 1, "R12", "busy start ignored", xfer_cnt - b_x, 1);

        // R13: pending trigger and overrun in beat mode.
        put_desc(32'h140, 3, 2, 1, 1, 1, 32'h26C, 32'h36C, 0);
        push_block(32'h260, 1, 32'h360, 1, 3, 2);
        b_w = nwr; b_o = ovr_cnt;
        go(32'h140, 2'd0);
        cyc(20);
        pulse(3);
        cyc(30);
        chk(nwr - b_w == 2, "R13", "held trigger ran", nwr - b_w, 2);
        chk(ovr_cnt - b_o == 1, "R13", "overrun pulses", ovr_cnt - b_o, 1);
        pulse(1);
        wait_idle();
        cyc(2);
        chk(nwr - b_w == 3, "R13", "after overrun", nwr - b_w, 3);

        // R14: triggers while idle are discarded.
        put_desc(32'h150, 1, 2, 1, 1, 1, 32'h274, 32'h374, 0);
        push_block(32'h270, 1, 32'h370, 1, 1, 2);
        b_w = nwr;
        pulse(1);
        cyc(2);
        pulse(1);
        go(32'h150, 2'd0);
        cyc(30);
        chk(nwr == b_w && busy, "R14", "idle trigger dropped", nwr - b_w, 0);
        pulse(1);
        wait_idle();
        cyc(2);
        chk(nwr - b_w == 1, "R14", "later trigger ran", nwr - b_w, 1);
        chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule